// File: doc/BRIEF.md
# Exception Return Frame Unwinder

This block performs the memory side of a return from exception. Given the supervisor stack pointer, it reads the stacked status word and return address over a simple read port. On an extended core it also reads the frame format word. It then works out how far the pointer must move to drop the whole frame. When it finishes, it presents the restored status word, the return program counter and the new stack pointer, together with a one-cycle done strobe.

A mode input, sampled at start, picks the core variant. A legacy core stacks only the status word and the return address. An extended core adds a format word, whose upper nibble selects how many extra bytes to skip. One format marks a throwaway frame. For that format the block takes the status word just read, moves the pointer past the frame, and unwinds the next stacked frame from there. An unknown format ends the unwind with no skip and raises an error flag.

Top module: `xret_unwinder`

## Requirements
- R1: After a start, the first read is a 16-bit request at SP. The status word is taken from `rd_data_i[15:0]`. The second read is a 32-bit request at SP+2, which gives the return PC. Memory is big-endian.
- R2: When `extended_i` was 0 at start, exactly two reads are made, no format word is read, and `sp_o` = SP+6 at done.
- R3: When `extended_i` was 1 at start, a third read (16-bit, at SP+6) fetches the format word. Bits 15:12 of that word are the format code. Format 0 gives `sp_o` = SP+8.
- R4: Formats 2 and 3 add 4 bytes to that pointer. Format 4 adds 8 bytes. Format 7 adds 52 bytes.
- R5: Format 1 commits the status word and the pointer SP+8, then runs the whole unwind again from SP+8. The final `sr_o`, `pc_o` and `sp_o` come from the second frame.
- R6: Any format code other than 0, 1, 2, 3, 4 or 7 sets `err_o` with done, and `sp_o` is left just past the format word. `err_o` is 0 for the known codes.
- R7: A read request stays high, with a stable address, until the cycle in which `rd_ack_i` is high. The two request lines are never high together.
- R8: `done_o` is high for exactly one cycle. `sr_o`, `pc_o`, `sp_o` and `err_o` then hold their values until the next accepted start.
- R9: A start while `busy_o` is high is ignored. It does not change the result and does not cause a second done.
- R10: During and after reset, `busy_o`, `done_o`, both request lines and `err_o` are 0, and `sr_o`, `pc_o` and `sp_o` are 0.
- R11: All pointer arithmetic wraps modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin an unwind (accepted only when idle) |
| extended_i | input | 1 | 1: core stacks a format word; 0: legacy core |
| sp_i | input | AW | Supervisor stack pointer at start |
| rd16_req_o | output | 1 | 16-bit read request |
| rd32_req_o | output | 1 | 32-bit read request |
| rd_addr_o | output | AW | Byte address of the current read |
| rd_ack_i | input | 1 | One-cycle read acknowledge with data |
| rd_data_i | input | 32 | Read data, right-aligned for 16-bit reads |
| busy_o | output | 1 | Unwind in progress |
| done_o | output | 1 | One-cycle completion strobe |
| err_o | output | 1 | Unknown frame format seen |
| sr_o | output | 16 | Restored status word |
| pc_o | output | 32 | Restored program counter |
| sp_o | output | AW | Stack pointer after the frame(s) |

## Verification
The bench builds the block with AW = 12, so its 4 KiB byte memory model covers the whole address space. With that width, a frame placed at 0xFFC crosses the top of the address space, which exercises the wrap of R11 on both the reads and the final pointer. The acknowledge latency changes from case to case, between zero and three wait cycles, so each read state both waits and advances on the acknowledge cycle.

// File: rtl/xret_pkg.sv
// Shared definitions for the exception return frame unwinder.
// Assumes byte addressing and big-endian words on the read port.
package xret_pkg;
    localparam int SKIP_W = 6;   // wide enough for the largest frame skip (52)

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SR,
        ST_PC,
        ST_FMT,
        ST_DONE
    } xret_state_e;
endpackage

// File: rtl/xret_fmt_decode.sv
// Frame format decoder: maps the format nibble to the number of extra
// bytes to skip, flags the throwaway (chain) format and unknown codes.
// Purely combinational; assumes the nibble is valid only when the
// sequencer is in its format-read state.
module xret_fmt_decode
    import xret_pkg::*;
(
    input  logic [3:0]        fmt_i,
    output logic [SKIP_W-1:0] skip_o,
    output logic              chain_o,
    output logic              bad_o
);
    // Decode the format code into skip length and class.
    always_comb begin
        skip_o  = '0;
        chain_o = 1'b0;
        bad_o   = 1'b0;
        case (fmt_i)
            4'd0:       skip_o = SKIP_W'(0);
            4'd1:       chain_o = 1'b1;
            4'd2, 4'd3: skip_o = SKIP_W'(4);
            4'd4:       skip_o = SKIP_W'(8);
            4'd7:       skip_o = SKIP_W'(52);
            default:    bad_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/xret_seq.sv
// Unwind sequencer: walks the stacked frame with 16/32-bit reads,
// holds each request until acknowledged, and loads the result
// registers. Assumes one outstanding read and a one-cycle acknowledge.
module xret_seq
    import xret_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              extended_i,
    input  logic [AW-1:0]     sp_i,
    input  logic              rd_ack_i,
    input  logic [31:0]       rd_data_i,
    input  logic [SKIP_W-1:0] skip_i,
    input  logic              chain_i,
    input  logic              bad_i,
    output logic              rd16_req_o,
    output logic              rd32_req_o,
    output logic [AW-1:0]     rd_addr_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [15:0]       sr_o,
    output logic [31:0]       pc_o,
    output logic [AW-1:0]     sp_o
);
    xret_state_e   state;
    logic [AW-1:0] ptr;
    logic [15:0]   sr_q;
    logic [31:0]   pc_q;
    logic          ext_q;

    // Advance the frame walk and load results on each acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ptr   <= '0;
            sr_q  <= '0;
            pc_q  <= '0;
            ext_q <= 1'b0;
            err_o <= 1'b0;
            sr_o  <= '0;
            pc_o  <= '0;
            sp_o  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        ptr   <= sp_i;
                        ext_q <= extended_i;
                        state <= ST_SR;
                    end
                end
                ST_SR: begin
                    if (rd_ack_i) begin
                        sr_q  <= rd_data_i[15:0];
                        ptr   <= ptr + AW'(2);
                        state <= ST_PC;
                    end
                end
                ST_PC: begin
                    if (rd_ack_i) begin
                        pc_q <= rd_data_i;
                        ptr  <= ptr + AW'(4);
                        if (ext_q) begin
                            state <= ST_FMT;
                        end else begin
                            sr_o  <= sr_q;
                            pc_o  <= rd_data_i;
                            sp_o  <= ptr + AW'(4);
                            err_o <= 1'b0;
                            state <= ST_DONE;
                        end
                    end
                end
                ST_FMT: begin
                    if (rd_ack_i) begin
                        sr_o <= sr_q;
                        if (chain_i) begin
                            sp_o  <= ptr + AW'(2);
                            ptr   <= ptr + AW'(2);
                            state <= ST_SR;
                        end else begin
                            pc_o  <= pc_q;
                            sp_o  <= ptr + AW'(2) + AW'(skip_i);
                            err_o <= bad_i;
                            state <= ST_DONE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the read port and status strobes from the state.
    always_comb begin
        rd16_req_o = (state == ST_SR) || (state == ST_FMT);
        rd32_req_o = (state == ST_PC);
        rd_addr_o  = ptr;
        busy_o     = (state != ST_IDLE);
        done_o     = (state == ST_DONE);
    end
endmodule

// File: rtl/xret_unwinder.sv
// Exception return frame unwinder top: joins the sequencer to the
// format decoder. The decoder looks at the upper nibble of the read
// data, which holds the format code when a format word is returned.
module xret_unwinder
    import xret_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          extended_i,
    input  logic [AW-1:0] sp_i,
    output logic          rd16_req_o,
    output logic          rd32_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_ack_i,
    input  logic [31:0]   rd_data_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o,
    output logic [15:0]   sr_o,
    output logic [31:0]   pc_o,
    output logic [AW-1:0] sp_o
);
    logic [SKIP_W-1:0] skip;
    logic              chain;
    logic              bad;

    xret_fmt_decode u_dec (
        .fmt_i   (rd_data_i[15:12]),
        .skip_o  (skip),
        .chain_o (chain),
        .bad_o   (bad)
    );

    xret_seq #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .extended_i (extended_i),
        .sp_i       (sp_i),
        .rd_ack_i   (rd_ack_i),
        .rd_data_i  (rd_data_i),
        .skip_i     (skip),
        .chain_i    (chain),
        .bad_i      (bad),
        .rd16_req_o (rd16_req_o),
        .rd32_req_o (rd32_req_o),
        .rd_addr_o  (rd_addr_o),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .err_o      (err_o),
        .sr_o       (sr_o),
        .pc_o       (pc_o),
        .sp_o       (sp_o)
    );
endmodule

// File: rtl/xret_unwinder_chk.sv
// Protocol checker for the unwinder, bound to the top module.
// Watches only the top-level ports.
module xret_unwinder_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          rd16_req_o,
    input logic          rd32_req_o,
    input logic [AW-1:0] rd_addr_o,
    input logic          rd_ack_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          err_o,
    input logic [15:0]   sr_o,
    input logic [31:0]   pc_o,
    input logic [AW-1:0] sp_o
);
    // R7: never two read widths at once
    a_r7_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd16_req_o && rd32_req_o));

    // R7: an unacknowledged 16-bit request persists at the same address
    a_r7_hold_rd16: assert property (@(posedge clk) disable iff (!rst_n)
        (rd16_req_o && !rd_ack_i) |=> (rd16_req_o && $stable(rd_addr_o)));

    // R7: an unacknowledged 32-bit request persists at the same address
    a_r7_hold_rd32: assert property (@(posedge clk) disable iff (!rst_n)
        (rd32_req_o && !rd_ack_i) |=> (rd32_req_o && $stable(rd_addr_o)));

    // R8: the done strobe lasts a single cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: results hold while idle and not started
    a_r8_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=>
        ($stable(sr_o) && $stable(pc_o) && $stable(sp_o) && $stable(err_o)));

    // R9: a start accepted when idle makes the block busy
    a_r9_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);
endmodule

bind xret_unwinder xret_unwinder_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .rd16_req_o (rd16_req_o),
    .rd32_req_o (rd32_req_o),
    .rd_addr_o  (rd_addr_o),
    .rd_ack_i   (rd_ack_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .sr_o       (sr_o),
    .pc_o       (pc_o),
    .sp_o       (sp_o)
);

// File: tb/xret_unwinder_tb.sv
// Scoreboard bench: the driver pushes expected results, the monitor
// pops and compares them on each done strobe.
module xret_unwinder_tb;
    localparam int AW         = 12;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [15:0]   sr;
        logic [31:0]   pc;
        logic [AW-1:0] sp;
        logic          err;
        int            reads;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          extended_i = 1'b0;
    logic [AW-1:0] sp_i = '0;
    logic          rd16_req_o, rd32_req_o;
    logic [AW-1:0] rd_addr_o;
    logic          rd_ack_i = 1'b0;
    logic [31:0]   rd_data_i = '0;
    logic          busy_o, done_o, err_o;
    logic [15:0]   sr_o;
    logic [31:0]   pc_o;
    logic [AW-1:0] sp_o;

    logic [7:0] mem [0:(1<<AW)-1];
    exp_t       exp_q [$];
    int         checks = 0;
    int         fails = 0;
    int         lat = 0;
    int         wait_cnt = 0;
    int         read_cnt = 0;
    logic [AW-1:0] first_addr = '0;
    logic       req_seen = 1'b0;
    logic       hold_chk = 1'b0;
    logic [15:0]   h_sr;
    logic [31:0]   h_pc;
    logic [AW-1:0] h_sp;
    logic          h_err;

    xret_unwinder #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .extended_i(extended_i),
        .sp_i(sp_i), .rd16_req_o(rd16_req_o), .rd32_req_o(rd32_req_o),
        .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .sr_o(sr_o), .pc_o(pc_o), .sp_o(sp_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put16(input logic [AW-1:0] a, input logic [15:0] v);
        mem[a]          = v[15:8];
        mem[a + AW'(1)] = v[7:0];
    endtask

    task automatic put32(input logic [AW-1:0] a, input logic [31:0] v);
        put16(a, v[31:16]);
        put16(a + AW'(2), v[15:0]);
    endtask

    // Memory responder: acknowledges after lat wait cycles, big-endian data.
    always @(negedge clk) begin
        if (!rst_n) begin
            rd_ack_i = 1'b0;
            wait_cnt = 0;
            req_seen = 1'b0;
        end else if (rd_ack_i) begin
            rd_ack_i = 1'b0;
            wait_cnt = 0;
            req_seen = 1'b0;
        end else if (rd16_req_o || rd32_req_o) begin
            if (!req_seen) begin
                first_addr = rd_addr_o;
                req_seen   = 1'b1;
            end
            if (wait_cnt >= lat) begin
                // R7: request held at one address, one width only
                check((rd_addr_o == first_addr) && !(rd16_req_o && rd32_req_o),
                      "R7", 32'(rd_addr_o), 32'(first_addr));
                if (rd16_req_o)
                    rd_data_i = {16'h0, mem[rd_addr_o], mem[rd_addr_o + AW'(1)]};
                else
                    rd_data_i = {mem[rd_addr_o], mem[rd_addr_o + AW'(1)],
                                 mem[rd_addr_o + AW'(2)], mem[rd_addr_o + AW'(3)]};
                rd_ack_i = 1'b1;
                read_cnt++;
            end else begin
                wait_cnt++;
            end
        end
    end

    // Monitor: compare results on done and check the hold cycle after it.
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_chk) begin
                check(!done_o, "R8 done width", 32'(done_o), 32'h0);
                check(sr_o == h_sr && pc_o == h_pc && sp_o == h_sp && err_o == h_err,
                      "R8 hold", pc_o, h_pc);
                hold_chk = 1'b0;
            end
            if (done_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected done", 32'h1, 32'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(sr_o == e.sr, {e.tag, " sr"}, 32'(sr_o), 32'(e.sr));
                    check(pc_o == e.pc, {e.tag, " pc"}, pc_o, e.pc);
                    check(sp_o == e.sp, {e.tag, " sp"}, 32'(sp_o), 32'(e.sp));
                    check(err_o == e.err, {e.tag, " err"}, 32'(err_o), 32'(e.err));
                    check(read_cnt == e.reads, {e.tag, " reads"}, read_cnt, e.reads);
                end
                h_sr = sr_o; h_pc = pc_o; h_sp = sp_o; h_err = err_o;
                hold_chk = 1'b1;
            end
        end
    end

    // Driver: push expectation, pulse start, optionally poke start while busy.
    task automatic run_case(input logic [AW-1:0] sp, input logic ext,
                            input logic [15:0] esr, input logic [31:0] epc,
                            input logic [AW-1:0] esp, input logic eerr,
                            input int ereads, input int l, input bit poke,
                            input string tag);
        exp_t e;
        e.sr = esr; e.pc = epc; e.sp = esp; e.err = eerr;
        e.reads = ereads; e.tag = tag;
        exp_q.push_back(e);
        lat = l;
        @(negedge clk);
        read_cnt   = 0;
        sp_i       = sp;
        extended_i = ext;
        start_i    = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            sp_i       = sp + AW'(12'h40);
            extended_i = ~ext;
            start_i    = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (busy_o) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) mem[i] = 8'h00;
        // legacy frame at 0x100, decoy format word left after it
        put16(12'h100, 16'h2704); put32(12'h102, 32'h12345678); put16(12'h106, 16'h7000);
        // format 0 at 0x200
        put16(12'h200, 16'h2000); put32(12'h202, 32'hCAFE0010); put16(12'h206, 16'h0064);
        // format 2 at 0x300, format 3 at 0x340, format 4 at 0x380, format 7 at 0x400
        put16(12'h300, 16'h2100); put32(12'h302, 32'h00001000); put16(12'h306, 16'h2018);
        put16(12'h340, 16'h2200); put32(12'h342, 32'h00002000); put16(12'h346, 16'h301C);
        put16(12'h380, 16'h2300); put32(12'h382, 32'h00003000); put16(12'h386, 16'h4008);
        put16(12'h400, 16'h2400); put32(12'h402, 32'h00004000); put16(12'h406, 16'h7008);
        // throwaway at 0x500 chaining to format 2 at 0x508
        put16(12'h500, 16'h2700); put32(12'h502, 32'hDEAD0000); put16(12'h506, 16'h1078);
        put16(12'h508, 16'h0015); put32(12'h50A, 32'hBEEF0004); put16(12'h50E, 16'h2010);
        // unknown formats 5 and F
        put16(12'h600, 16'h2500); put32(12'h602, 32'h00005000); put16(12'h606, 16'h5000);
        put16(12'h640, 16'h2600); put32(12'h642, 32'h00006000); put16(12'h646, 16'hF000);
        // legacy frame crossing the top of the address space
        put16(12'hFFC, 16'h1F1F); put32(12'hFFE, 32'hA1B2C3D4);
        // frame for the busy-poke case
        put16(12'h700, 16'h2055); put32(12'h702, 32'h77778888); put16(12'h706, 16'h0000);
        put16(12'h740, 16'h3333); put32(12'h742, 32'h99990000); put16(12'h746, 16'h0000);

        repeat (3) @(negedge clk);
        // R10: outputs during reset
        check(!busy_o && !done_o && !rd16_req_o && !rd32_req_o && !err_o,
              "R10 strobes", {27'h0, busy_o, done_o, rd16_req_o, rd32_req_o, err_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(sr_o == 16'h0 && pc_o == 32'h0 && sp_o == '0 && !busy_o,
              "R10 values", pc_o, 32'h0);

        run_case(12'h100, 1'b0, 16'h2704, 32'h12345678, 12'h106, 1'b0, 2, 0, 0, "R1 R2 legacy");
        run_case(12'h200, 1'b1, 16'h2000, 32'hCAFE0010, 12'h208, 1'b0, 3, 1, 0, "R3 fmt0");
        run_case(12'h300, 1'b1, 16'h2100, 32'h00001000, 12'h30C, 1'b0, 3, 2, 0, "R4 fmt2");
        run_case(12'h340, 1'b1, 16'h2200, 32'h00002000, 12'h34C, 1'b0, 3, 0, 0, "R4 fmt3");
        run_case(12'h380, 1'b1, 16'h2300, 32'h00003000, 12'h390, 1'b0, 3, 3, 0, "R4 fmt4");
        run_case(12'h400, 1'b1, 16'h2400, 32'h00004000, 12'h43C, 1'b0, 3, 1, 0, "R4 fmt7");
        run_case(12'h500, 1'b1, 16'h0015, 32'hBEEF0004, 12'h514, 1'b0, 6, 1, 0, "R5 throwaway");
        run_case(12'h600, 1'b1, 16'h2500, 32'h00005000, 12'h608, 1'b1, 3, 0, 0, "R6 fmt5");
        run_case(12'h640, 1'b1, 16'h2600, 32'h00006000, 12'h648, 1'b1, 3, 2, 0, "R6 fmtF");
        run_case(12'hFFC, 1'b0, 16'h1F1F, 32'hA1B2C3D4, 12'h002, 1'b0, 2, 1, 0, "R11 wrap");
        run_case(12'h700, 1'b1, 16'h2055, 32'h77778888, 12'h708, 1'b0, 3, 2, 1, "R9 poke");

        repeat (10) @(negedge clk);
        // R9: the ignored start left nothing running
        check(!busy_o && exp_q.size() == 0, "R9 idle after poke",
              32'(busy_o), 32'h0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule